// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address for a processor core. A request carries the address and three access flags: write or read, instruction fetch or data, user or privileged. With translation switched off, the address passes straight through. With translation on, the walker reads one descriptor from a first-level table and, for coarse entries, a second descriptor from a second-level table. It reads them one word at a time over a simple memory read port. It then returns a physical address together with the granted access level, or a fault code.

Four mapping sizes are supported: 1 MB sections, 64 KB large pages, 4 KB small pages and 1 KB tiny pages. A 32-bit domain control word gives each of sixteen domains a 2-bit mode: no access, checked, reserved or manager. A 2-bit permission field, qualified by two system control bits, grants a level of none, read-only or read/write.

A data fault loads the fault address and fault status registers and pulses a data abort. An instruction-fetch fault pulses a prefetch abort and leaves both registers as they were. A quiet flag reports the failure without touching the registers and without any abort. The walker handles one translation at a time.

Top module: `mmu_walker`

## Requirements
- R1: With `mmu_on` low at acceptance, the response is OK with PA equal to VA and level 2, and no memory read is issued.
- R2: The first-level word is read from `table_base + 4*VA[31:20]`. Its bits [1:0] select the entry type: 2 is a section, 1 is a coarse table, and 0 or 3 is a translation fault with status 0x5 and domain 0.
- R3: The domain is descriptor bits [8:5]. Its mode is `domain_ctl[2*dom+1:2*dom]`. Mode 0 or 2 faults with status 0x9 for a section or 0xB for a coarse entry, and no second-level read is made. Mode 3 grants level 2 whatever the permission field holds. Mode 1 applies the permission check.
- R4: A section maps PA = {desc[31:20], VA[19:0]}, with its permission field in desc[11:10].
- R5: A coarse entry's second-level word is read from `{desc[31:10],10'b0} + 4*VA[19:12]`. Type 0 in bits [1:0] of that word is a page translation fault with status 0x7, reported with the first-level domain.
- R6: A large page (type 1) maps PA = {d2[31:16], VA[15:0]}. Its permission field is d2[5:4], [7:6], [9:8] or [11:10] for VA[15:14] = 0, 1, 2 or 3.
- R7: A small page (type 2) maps PA = {d2[31:12], VA[11:0]}. Its permission field is picked the same way by VA[11:10].
- R8: A tiny page (type 3) maps PA = {d2[31:10], VA[9:0]}, with its permission field in d2[5:4].
- R9: Permission 1 gives privileged level 2 and user level 0. Permission 2 gives privileged 2 and user 1. Permission 3 gives 2 to all. Permission 0 depends on `ap0_sys` and `ap0_rom`: neither set gives 0; sys alone gives privileged 1 and user 0; rom alone gives 1 to all; both set gives 0.
- R10: An access succeeds only when its level is greater than 1 for a write and greater than 0 for a read. Otherwise it faults with status 0xD for a section or 0xF for a page. On success `rsp_status` is 0.
- R11: A data-access fault loads `fault_addr` with VA and `fault_stat` with {domain, status}, and raises `abort_data` during the response. An instruction-fetch fault raises `abort_fetch` instead and leaves both registers unchanged.
- R12: With `req_quiet` set, a fault is still reported on `rsp_ok` and `rsp_status`, but no abort is raised and the fault registers hold.
- R13: `rsp_partial` is 1 for a successful tiny-page access, and for a successful small-page access whose four permission fields are not all equal. In every other case it is 0.
- R14: `req_ready` is high only while idle. `rsp_valid` is a single-cycle pulse. `mem_rd` is a single-cycle pulse, issued once per level walked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_on | input | 1 | Translation enable |
| ap0_sys | input | 1 | System control bit that qualifies permission 0 |
| ap0_rom | input | 1 | ROM control bit that qualifies permission 0 |
| table_base | input | 32 | First-level table base address |
| domain_ctl | input | 32 | Sixteen 2-bit domain modes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access |
| req_fetch | input | 1 | 1 for an instruction fetch |
| req_user | input | 1 | 1 for a user-mode access |
| req_quiet | input | 1 | Report a fault without updating registers or raising an abort |
| mem_rd | output | 1 | Descriptor read strobe |
| mem_addr | output | 32 | Descriptor word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_pa | output | 32 | Physical address |
| rsp_level | output | 2 | Granted level: 0 none, 1 read-only, 2 read/write |
| rsp_partial | output | 1 | Mapping is finer than a full page |
| rsp_status | output | 4 | Fault status code, 0 on success |
| fault_addr | output | 32 | Fault address register |
| fault_stat | output | 8 | Fault status register {domain, status} |
| abort_data | output | 1 | Data abort pulse |
| abort_fetch | output | 1 | Prefetch abort pulse |

## Verification
The assertions check the protocol rules on every cycle. They confirm that the read strobe and response are single-cycle pulses, that a bypass request answers in the next cycle with the untranslated address, that the two aborts never fire together, that a fetch fault or a quiet request leaves the fault registers unchanged, and that a successful response always carries a level above the write flag with a zero status. Only the bench scenarios can show the rest. That covers the address arithmetic of both table levels, the choice of permission field by address bits in each page size, the permission and domain tables, and the status and domain codes written for each fault kind. It also covers the partial-page flag and behaviour under slower memory.

// File: rtl/mmu_walker.sv
module mmu_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mmu_on,
  input  logic        ap0_sys,
  input  logic        ap0_rom,
  input  logic [31:0] table_base,
  input  logic [31:0] domain_ctl,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic        req_write,
  input  logic        req_fetch,
  input  logic        req_user,
  input  logic        req_quiet,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        rsp_valid,
  output logic        rsp_ok,
  output logic [31:0] rsp_pa,
  output logic [1:0]  rsp_level,
  output logic        rsp_partial,
  output logic [3:0]  rsp_status,
  output logic [31:0] fault_addr,
  output logic [7:0]  fault_stat,
  output logic        abort_data,
  output logic        abort_fetch
);

  typedef enum logic [2:0] {S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE} st_t;

  localparam logic [3:0] ST_SEC_XLT  = 4'h5;
  localparam logic [3:0] ST_PG_XLT   = 4'h7;
  localparam logic [3:0] ST_SEC_DOM  = 4'h9;
  localparam logic [3:0] ST_PG_DOM   = 4'hB;
  localparam logic [3:0] ST_SEC_PERM = 4'hD;
  localparam logic [3:0] ST_PG_PERM  = 4'hF;

  st_t         st;
  logic [31:0] va, d1;
  logic        wr, fetch, user, quiet;

  function automatic logic [1:0] ap_level(input logic [1:0] ap, input logic [1:0] mode,
                                          input logic usr, input logic s, input logic r);
    if (mode == 2'd3) return 2'd2;
    case (ap)
      2'd0: case ({r, s})
              2'b01:   return usr ? 2'd0 : 2'd1;
              2'b10:   return 2'd1;
              default: return 2'd0;
            endcase
      2'd1: return usr ? 2'd0 : 2'd2;
      2'd2: return usr ? 2'd1 : 2'd2;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [1:0] pick_ap(input logic [31:0] d, input logic [1:0] sel);
    case (sel)
      2'd0: return d[5:4];
      2'd1: return d[7:6];
      2'd2: return d[9:8];
      default: return d[11:10];
    endcase
  endfunction

  logic [3:0]  l1_dom;
  logic [1:0]  l1_mode, l2_mode, l1_lvl, l2_lvl, l2_ap;
  logic [31:0] l2_pa;
  logic        l2_part;

  assign l1_dom  = mem_rdata[8:5];
  assign l1_mode = domain_ctl[{l1_dom, 1'b0} +: 2];
  assign l2_mode = domain_ctl[{d1[8:5], 1'b0} +: 2];
  assign l1_lvl  = ap_level(mem_rdata[11:10], l1_mode, user, ap0_sys, ap0_rom);
  assign l2_lvl  = ap_level(l2_ap, l2_mode, user, ap0_sys, ap0_rom);

  always_comb begin
    case (mem_rdata[1:0])
      2'd1: begin
        l2_ap   = pick_ap(mem_rdata, va[15:14]);
        l2_pa   = {mem_rdata[31:16], va[15:0]};
        l2_part = 1'b0;
      end
      2'd2: begin
        l2_ap   = pick_ap(mem_rdata, va[11:10]);
        l2_pa   = {mem_rdata[31:12], va[11:0]};
        l2_part = !((mem_rdata[5:4] == mem_rdata[7:6]) && (mem_rdata[5:4] == mem_rdata[9:8]) &&
                    (mem_rdata[5:4] == mem_rdata[11:10]));
      end
      default: begin
        l2_ap   = mem_rdata[5:4];
        l2_pa   = {mem_rdata[31:10], va[9:0]};
        l2_part = 1'b1;
      end
    endcase
  end

  logic        fin, go_l2, f_ok, f_part;
  logic [31:0] f_pa;
  logic [1:0]  f_lvl;
  logic [3:0]  f_st, f_dom;

  always_comb begin
    fin = 1'b0; go_l2 = 1'b0; f_ok = 1'b0; f_pa = va; f_lvl = 2'd0;
    f_part = 1'b0; f_st = 4'h0; f_dom = 4'h0;
    case (st)
      S_IDLE: if (req_valid && !mmu_on) begin
        fin = 1'b1; f_ok = 1'b1; f_pa = req_va; f_lvl = 2'd2;
      end
      S_L1_WAIT: if (mem_rvalid) begin
        case (mem_rdata[1:0])
          2'd2: begin
            fin = 1'b1; f_dom = l1_dom;
            if (!l1_mode[0])                f_st = ST_SEC_DOM;
            else if (l1_lvl > {1'b0, wr}) begin
              f_ok = 1'b1; f_lvl = l1_lvl; f_pa = {mem_rdata[31:20], va[19:0]};
            end else                        f_st = ST_SEC_PERM;
          end
          2'd1: begin
            if (!l1_mode[0]) begin fin = 1'b1; f_dom = l1_dom; f_st = ST_PG_DOM; end
            else go_l2 = 1'b1;
          end
          default: begin fin = 1'b1; f_st = ST_SEC_XLT; end
        endcase
      end
      S_L2_WAIT: if (mem_rvalid) begin
        fin = 1'b1; f_dom = d1[8:5];
        if (mem_rdata[1:0] == 2'd0)      f_st = ST_PG_XLT;
        else if (l2_lvl > {1'b0, wr}) begin
          f_ok = 1'b1; f_lvl = l2_lvl; f_pa = l2_pa; f_part = l2_part;
        end else                         f_st = ST_PG_PERM;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; va <= '0; d1 <= '0; wr <= 1'b0; fetch <= 1'b0; user <= 1'b0; quiet <= 1'b0;
      rsp_ok <= 1'b0; rsp_pa <= '0; rsp_level <= '0; rsp_partial <= 1'b0; rsp_status <= '0;
      fault_addr <= '0; fault_stat <= '0;
    end else begin
      if (st == S_IDLE && req_valid) begin
        va <= req_va; wr <= req_write; fetch <= req_fetch; user <= req_user; quiet <= req_quiet;
        if (mmu_on) st <= S_L1_REQ;
      end
      case (st)
        S_L1_REQ: st <= S_L1_WAIT;
        S_L2_REQ: st <= S_L2_WAIT;
        S_DONE:   st <= S_IDLE;
        S_L1_WAIT: if (go_l2) begin d1 <= mem_rdata; st <= S_L2_REQ; end
        default: ;
      endcase
      if (fin) begin
        st <= S_DONE;
        rsp_ok <= f_ok; rsp_pa <= f_pa; rsp_level <= f_lvl;
        rsp_partial <= f_part; rsp_status <= f_st;
        if (!f_ok && !fetch && !quiet) begin
          fault_addr <= va;
          fault_stat <= {f_dom, f_st};
        end
      end
    end
  end

  assign req_ready   = (st == S_IDLE);
  assign rsp_valid   = (st == S_DONE);
  assign mem_rd      = (st == S_L1_REQ) || (st == S_L2_REQ);
  assign mem_addr    = (st == S_L1_REQ) ? table_base + {18'b0, va[31:20], 2'b00} :
                       (st == S_L2_REQ) ? {d1[31:10], 10'b0} + {22'b0, va[19:12], 2'b00} : 32'h0;
  assign abort_data  = rsp_valid && !rsp_ok && !fetch && !quiet;
  assign abort_fetch = rsp_valid && !rsp_ok && fetch && !quiet;

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> !mem_rd); // R14
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R14
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !mmu_on) |=> (rsp_valid && rsp_ok && rsp_pa == $past(req_va))); // R1
  AST_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(abort_data && abort_fetch)); // R11
  AST_FETCH_HOLDS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_fetch |-> ($stable(fault_addr) && $stable(fault_stat))); // R11
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && quiet) |-> (!abort_data && !abort_fetch && $stable(fault_stat))); // R12
  AST_OK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok) |-> (rsp_status == 4'h0 && rsp_level > {1'b0, wr})); // R10
  AST_PARTIAL_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> !rsp_partial); // R13

endmodule

// File: tb/mmu_walker_tb_top.sv
`timescale 1ns/1ps
module mmu_walker_tb_top;

  localparam logic [31:0] TB_BASE = 32'h0004_0000;
  localparam logic [31:0] DOMS    = 32'h0000_008D; // dom0 checked, dom1 manager, dom2 none, dom3 reserved

  typedef struct packed {
    logic on, s, r, usr, wr;
    logic [31:0] va, l1, l2;
    logic ok;
    logic [31:0] pa;
    logic [1:0] lvl;
    logic part;
    logic [3:0] st, dom;
    logic [7:0] tag;
  } vec_t;

  function automatic logic [31:0] sec(input logic [11:0] b, input logic [1:0] ap, input logic [3:0] d);
    return {b, 8'h00, ap, 1'b0, d, 1'b0, 2'b00, 2'b10};
  endfunction
  function automatic logic [31:0] cor(input logic [21:0] b, input logic [3:0] d);
    return {b, 1'b0, d, 1'b0, 2'b00, 2'b01};
  endfunction
  function automatic logic [31:0] lrg(input logic [15:0] b, input logic [1:0] a3, a2, a1, a0);
    return {b, 4'h0, a3, a2, a1, a0, 2'b00, 2'b01};
  endfunction
  function automatic logic [31:0] sml(input logic [19:0] b, input logic [1:0] a3, a2, a1, a0);
    return {b, a3, a2, a1, a0, 2'b00, 2'b10};
  endfunction
  function automatic logic [31:0] tny(input logic [21:0] b, input logic [1:0] ap);
    return {b, 4'h0, ap, 2'b00, 2'b11};
  endfunction

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 32'h1234_5678, 32'h0, 32'h0, 1'b1, 32'h1234_5678, 2'd2,1'b0, 4'h0,4'h0, 8'd1},  // R1
    '{1'b1,1'b0,1'b0,1'b0,1'b1, 32'h0AB1_2345, sec(12'h7C3,2'd1,4'd0), 32'h0, 1'b1, 32'h7C31_2345, 2'd2,1'b0, 4'h0,4'h0, 8'd4}, // R4
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0AB0_0010, sec(12'h7C3,2'd1,4'd0), 32'h0, 1'b0, 32'h0, 2'd0,1'b0, 4'hD,4'h0, 8'd9}, // R9
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0020_0044, sec(12'h100,2'd2,4'd0), 32'h0, 1'b1, 32'h1000_0044, 2'd1,1'b0, 4'h0,4'h0, 8'd9}, // R9
    '{1'b1,1'b0,1'b0,1'b1,1'b1, 32'h0020_0044, sec(12'h100,2'd2,4'd0), 32'h0, 1'b0, 32'h0, 2'd0,1'b0, 4'hD,4'h0, 8'd10}, // R10
    '{1'b1,1'b0,1'b0,1'b1,1'b1, 32'h0030_0ABC, sec(12'h555,2'd1,4'd1), 32'h0, 1'b1, 32'h5550_0ABC, 2'd2,1'b0, 4'h0,4'h0, 8'd3}, // R3
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0030_0ABC, sec(12'h555,2'd3,4'd2), 32'h0, 1'b0, 32'h0, 2'd0,1'b0, 4'h9,4'h2, 8'd3}, // R3
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0031_0000, cor(22'h00123,4'd3), 32'h0, 1'b0, 32'h0, 2'd0,1'b0, 4'hB,4'h3, 8'd3}, // R3
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0000_0000, 32'h0000_01E0, 32'h0, 1'b0, 32'h0, 2'd0,1'b0, 4'h5,4'h0, 8'd2}, // R2
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 32'hFFF0_0000, 32'h0000_0043, 32'h0, 1'b0, 32'h0, 2'd0,1'b0, 4'h5,4'h0, 8'd2}, // R2
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0040_1000, sec(12'h200,2'd0,4'd0), 32'h0, 1'b0, 32'h0, 2'd0,1'b0, 4'hD,4'h0, 8'd9}, // R9
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 32'h0040_1000, sec(12'h200,2'd0,4'd0), 32'h0, 1'b1, 32'h2000_1000, 2'd1,1'b0, 4'h0,4'h0, 8'd9}, // R9
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 32'h0040_1000, sec(12'h200,2'd0,4'd0), 32'h0, 1'b0, 32'h0, 2'd0,1'b0, 4'hD,4'h0, 8'd9}, // R9
    '{1'b1,1'b0,1'b1,1'b1,1'b0, 32'h0040_1000, sec(12'h200,2'd0,4'd0), 32'h0, 1'b1, 32'h2000_1000, 2'd1,1'b0, 4'h0,4'h0, 8'd9}, // R9
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 32'h0040_1000, sec(12'h200,2'd0,4'd0), 32'h0, 1'b0, 32'h0, 2'd0,1'b0, 4'hD,4'h0, 8'd9}, // R9
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 32'h0040_1000, sec(12'h200,2'd0,4'd0), 32'h0, 1'b0, 32'h0, 2'd0,1'b0, 4'hD,4'h0, 8'd10}, // R10
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 32'h1234_4765, cor(22'h00400,4'd0), lrg(16'hABCD,2'd3,2'd0,2'd2,2'd1), 1'b1, 32'hABCD_4765, 2'd1,1'b0, 4'h0,4'h0, 8'd6}, // R6
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 32'h1234_8765, cor(22'h00400,4'd0), lrg(16'hABCD,2'd3,2'd0,2'd2,2'd1), 1'b0, 32'h0, 2'd0,1'b0, 4'hF,4'h0, 8'd6}, // R6
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0050_0C21, cor(22'h00500,4'd0), sml(20'h81234,2'd1,2'd3,2'd2,2'd2), 1'b0, 32'h0, 2'd0,1'b0, 4'hF,4'h0, 8'd7}, // R7
    '{1'b1,1'b0,1'b0,1'b1,1'b1, 32'h0050_0821, cor(22'h00500,4'd0), sml(20'h81234,2'd1,2'd3,2'd2,2'd2), 1'b1, 32'h8123_4821, 2'd2,1'b1, 4'h0,4'h0, 8'd7}, // R7 R13
    '{1'b1,1'b0,1'b0,1'b0,1'b1, 32'h0060_0777, cor(22'h00500,4'd0), sml(20'h00ABC,2'd3,2'd3,2'd3,2'd3), 1'b1, 32'h00AB_C777, 2'd2,1'b0, 4'h0,4'h0, 8'd13}, // R13
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0070_03FF, cor(22'h00500,4'd0), tny(22'h12345,2'd2), 1'b1, 32'h048D_17FF, 2'd1,1'b1, 4'h0,4'h0, 8'd8}, // R8
    '{1'b1,1'b0,1'b0,1'b1,1'b1, 32'h0080_0000, cor(22'h00600,4'd1), tny(22'h12345,2'd1), 1'b1, 32'h048D_1400, 2'd2,1'b1, 4'h0,4'h0, 8'd3}, // R3
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0080_0000, cor(22'h00600,4'd1), 32'h0000_0FF0, 1'b0, 32'h0, 2'd0,1'b0, 4'h7,4'h1, 8'd5}  // R5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        mmu_on = 1'b0, ap0_sys = 1'b0, ap0_rom = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_user = 1'b0, req_quiet = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready, mem_rd, mem_rvalid, rsp_valid, rsp_ok, rsp_partial, abort_data, abort_fetch;
  logic [31:0] mem_addr, mem_rdata, rsp_pa, fault_addr;
  logic [1:0]  rsp_level;
  logic [3:0]  rsp_status;
  logic [7:0]  fault_stat;

  mmu_walker dut_i (
    .clk(clk), .rst_n(rst_n), .mmu_on(mmu_on), .ap0_sys(ap0_sys), .ap0_rom(ap0_rom),
    .table_base(TB_BASE), .domain_ctl(DOMS),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
    .req_fetch(req_fetch), .req_user(req_user), .req_quiet(req_quiet),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_pa(rsp_pa), .rsp_level(rsp_level),
    .rsp_partial(rsp_partial), .rsp_status(rsp_status), .fault_addr(fault_addr),
    .fault_stat(fault_stat), .abort_data(abort_data), .abort_fetch(abort_fetch)
  );

  // memory model: serves the expected descriptor addresses only
  logic [31:0] cur_l1 = '0, cur_l2 = '0, raddr = '0;
  int          lat = 0, cnt = 0, rd_total = 0, bad_total = 0;
  logic        pend = 1'b0;
  initial begin mem_rvalid = 1'b0; mem_rdata = '0; end

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_rd) begin
      pend <= 1'b1; cnt <= lat; raddr <= mem_addr; rd_total <= rd_total + 1;
    end else if (pend) begin
      if (cnt == 0) begin
        pend <= 1'b0; mem_rvalid <= 1'b1;
        if (raddr == TB_BASE + {18'b0, req_va[31:20], 2'b00}) mem_rdata <= cur_l1;
        else if (raddr == {cur_l1[31:10], 10'b0} + {22'b0, req_va[19:12], 2'b00}) mem_rdata <= cur_l2;
        else begin mem_rdata <= 32'h0; bad_total <= bad_total + 1; end
      end else cnt <= cnt - 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit cond, input int tag, input string what, input logic [31:0] act, exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  logic        s_ok, s_part, s_abd, s_abf, s_busy_ready;
  logic [31:0] s_pa, s_far;
  logic [1:0]  s_lvl;
  logic [3:0]  s_st;
  logic [7:0]  s_fsr;
  int          s_reads, s_bad;

  task automatic run(input vec_t v, input logic fetch, input logic quiet);
    int r0, b0, guard;
    @(negedge clk);
    mmu_on = v.on; ap0_sys = v.s; ap0_rom = v.r; req_user = v.usr; req_write = v.wr;
    req_fetch = fetch; req_quiet = quiet; req_va = v.va; cur_l1 = v.l1; cur_l2 = v.l2;
    r0 = rd_total; b0 = bad_total; s_busy_ready = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 60) begin
      if (req_ready) s_busy_ready = 1'b1;
      @(negedge clk);
      guard++;
    end
    s_ok = rsp_ok; s_pa = rsp_pa; s_lvl = rsp_level; s_part = rsp_partial; s_st = rsp_status;
    s_abd = abort_data; s_abf = abort_fetch; s_far = fault_addr; s_fsr = fault_stat;
    s_reads = rd_total - r0; s_bad = bad_total - b0;
    chk(rsp_valid, 14, "response seen", {31'b0, rsp_valid}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R14 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] far0;
    logic [7:0]  fsr0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd == 1'b0, 14, "reset idle",
        {29'b0, req_ready, rsp_valid, mem_rd}, 32'h4);
    chk(fault_addr == 32'h0 && fault_stat == 8'h0, 11, "reset fault regs", {fault_stat, fault_addr[23:0]}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i], 1'b0, 1'b0);
      chk(s_bad == 0, VECS[i].tag, "descriptor address", s_bad, 0);
      chk(s_ok == VECS[i].ok, VECS[i].tag, "ok", {31'b0, s_ok}, {31'b0, VECS[i].ok});
      chk(s_st == VECS[i].st, VECS[i].tag, "status", {28'b0, s_st}, {28'b0, VECS[i].st});
      chk(s_abd == !VECS[i].ok && !s_abf, 11, "data abort", {30'b0, s_abd, s_abf}, {30'b0, !VECS[i].ok, 1'b0});
      if (VECS[i].ok) begin
        chk(s_pa == VECS[i].pa, VECS[i].tag, "pa", s_pa, VECS[i].pa);
        chk(s_lvl == VECS[i].lvl, VECS[i].tag, "level", {30'b0, s_lvl}, {30'b0, VECS[i].lvl});
        chk(s_part == VECS[i].part, 13, "partial", {31'b0, s_part}, {31'b0, VECS[i].part});
      end else begin
        chk(s_far == VECS[i].va, 11, "fault addr", s_far, VECS[i].va);
        chk(s_fsr == {VECS[i].dom, VECS[i].st}, 11, "fault stat", {24'b0, s_fsr}, {24'b0, VECS[i].dom, VECS[i].st});
      end
    end

    // R1 bypass makes no read
    run(VECS[0], 1'b0, 1'b0);
    chk(s_reads == 0, 1, "bypass reads", s_reads, 0);

    // R11 instruction fetch fault: prefetch abort, registers hold
    far0 = fault_addr; fsr0 = fault_stat;
    run(VECS[2], 1'b1, 1'b0);
    chk(s_abf == 1'b1 && s_abd == 1'b0, 11, "prefetch abort", {30'b0, s_abd, s_abf}, 32'h1);
    chk(s_far == far0 && s_fsr == fsr0, 11, "fetch keeps regs", {s_fsr, s_far[23:0]}, {fsr0, far0[23:0]});
    chk(s_st == 4'hD, 11, "fetch status", {28'b0, s_st}, 32'hD);

    // R12 quiet data fault
    run(VECS[6], 1'b0, 1'b1);
    chk(s_ok == 1'b0 && s_st == 4'h9, 12, "quiet reports", {27'b0, s_ok, s_st}, 32'h9);
    chk(s_abd == 1'b0 && s_abf == 1'b0, 12, "quiet no abort", {30'b0, s_abd, s_abf}, 32'h0);
    chk(s_far == far0 && s_fsr == fsr0, 12, "quiet keeps regs", {s_fsr, s_far[23:0]}, {fsr0, far0[23:0]});

    // R3 domain fault on coarse entry makes one read only
    run(VECS[7], 1'b0, 1'b0);
    chk(s_reads == 1, 3, "coarse domain fault reads", s_reads, 1);

    // R14 slow memory, two-level walk
    lat = 3;
    run(VECS[19], 1'b0, 1'b0);
    chk(s_reads == 2, 14, "two reads", s_reads, 2);
    chk(s_busy_ready == 1'b0, 14, "not ready while busy", {31'b0, s_busy_ready}, 32'h0);
    chk(s_ok && s_pa == 32'h8123_4821, 7, "slow small page pa", s_pa, 32'h8123_4821);
    run(VECS[1], 1'b0, 1'b0);
    chk(s_reads == 1 && s_pa == 32'h7C31_2345, 4, "slow section", s_pa, 32'h7C31_2345);
    lat = 0;

    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, 14, "single-cycle response", {30'b0, rsp_valid, req_ready}, 32'h1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule